// File: doc/BRIEF.md
# Dual-Word Bitfield Extractor

This block pulls an unsigned bitfield out of a 64-bit value built from two 32-bit operand words. The caller supplies a low word, a high word, a starting bit position and a field length. The block shifts the joined pair right by the position and keeps the low word. It then clears every bit above the requested length and returns the zero-extended field.

It is an ALU-style datapath. With the default setting, a single output register stage holds the field result and a valid strobe that follows the input strobe one cycle later. With the register disabled, the path is purely combinational and the strobe passes straight through. The position operand is limited to a shift range twice the word width. Shifts beyond that range give zero. A length of zero selects a full-width field.

Top module: `bitfield_pull`

## Requirements
- R1: The 64-bit source has `hi_word` in bits 63..32 and `lo_word` in bits 31..0, so position 32 with a full-width field returns `hi_word` unchanged.
- R2: Only `pos[6:0]` forms the shift amount. Setting any of `pos[31:7]` leaves the result unchanged.
- R3: When `pos[6:0]` is 64 or more (64..127), the result is zero whatever the words and length are.
- R4: For `pos[6:0]` below 64, the source is shifted right logically and the low 32 bits are kept. Bits shifted in from above bit 63 are zero.
- R5: A length N in 1..31 keeps the low N bits of the shifted value and clears bits 31..N.
- R6: A length of zero returns the shifted low word with no bits cleared.
- R7: Only `len[5:0]` sets the length. Values 32..63 in those bits select the full 32-bit field, and `len[31:6]` has no effect.
- R8: A field that crosses bit 32 returns the high bits of `lo_word` below the low bits of `hi_word`. For example, position 28 with length 8 returns `{hi_word[3:0], lo_word[31:28]}`.
- R9: With the output register enabled, `result` and `out_valid` reflect the operands sampled at a rising edge where `in_valid` was high, one cycle later. A synchronous active-high `rst` clears `out_valid`.
- R10: With the output register enabled, a rising edge with `in_valid` low clears `out_valid` at that edge and leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset of the valid flag |
| in_valid | input | 1 | Operands on this cycle are to be extracted |
| lo_word | input | 32 | Bits 31..0 of the source pair |
| hi_word | input | 32 | Bits 63..32 of the source pair |
| pos | input | 32 | Bit position of the field's least significant bit; low 7 bits used |
| len | input | 32 | Field length; low 6 bits used, 0 means 32 |
| out_valid | output | 1 | Result holds a fresh extraction |
| result | output | 32 | Zero-extended extracted field |

## Verification
The hardest cases to reach from the ports are those where an ignored operand bit or an out-of-range encoding could leak into the result. Examples are a position whose bit 6 is set while the low six bits would select a valid shift, and a length whose low six bits are zero while higher bits are set. The stimulus aims directed vectors at those aliasing points: positions 64, 127 and 64+28, and lengths 64 and 65. It uses word values whose bit patterns differ in every nibble, so a wrong shift or mask shows up. Directed vectors at the word boundary and the length extremes come first. A run of random vectors follows, and each one is compared against an independent 64-bit shift-and-mask model.

// File: rtl/bitfield_pull.sv
module bitfield_pull #(
  parameter int WORD_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] pos,
  input  logic [WORD_W-1:0] len,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  localparam int DW    = 2 * WORD_W;
  localparam int SH_W  = $clog2(DW);
  localparam int POS_W = SH_W + 1;
  localparam int LEN_W = $clog2(WORD_W) + 1;

  logic [POS_W-1:0]  shamt;
  logic [LEN_W-1:0]  flen;
  logic [DW-1:0]     slid;
  logic              full;
  logic [WORD_W-1:0] keep;
  logic [WORD_W-1:0] field;
  logic              unused_bits;

  assign shamt = pos[POS_W-1:0];
  assign flen  = len[LEN_W-1:0];
  assign slid  = {hi_word, lo_word} >> shamt[SH_W-1:0];
  assign full  = (flen == '0) || flen[LEN_W-1];
  assign keep  = full ? '1 : ~({WORD_W{1'b1}} << flen[LEN_W-2:0]);
  assign field = shamt[POS_W-1] ? '0 : (slid[WORD_W-1:0] & keep);
  assign unused_bits = ^{pos[WORD_W-1:POS_W], len[WORD_W-1:LEN_W], slid[DW-1:WORD_W]};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
      if (in_valid) result <= field;
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> out_valid == $past(in_valid));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

    // R3
    far_shift_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pos[POS_W-1]) |=> result == '0);

    // R5
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && flen != '0 && !flen[LEN_W-1]) |=> (result >> $past(flen)) == '0);

    // R8
    straddle_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && shamt == POS_W'(WORD_W - 4) && flen == LEN_W'(8)) |=>
      result == ((($past(hi_word) << 4) | ($past(lo_word) >> (WORD_W - 4)))
                 & {{(WORD_W-8){1'b0}}, 8'hFF}));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = field;
  end
endmodule

// File: tb/sim_bitfield_pull.sv
module sim_bitfield_pull;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] lo_word = '0, hi_word = '0, pos = '0, len = '0;
  logic        out_valid;
  logic [31:0] result;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp = '0;

  always #10 clk = ~clk;

  bitfield_pull u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .lo_word(lo_word), .hi_word(hi_word), .pos(pos), .len(len),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model(logic [31:0] lo, logic [31:0] hi,
                                        logic [31:0] p, logic [31:0] n);
    logic [63:0] v;
    logic [63:0] m;
    int s;
    int k;
    s = int'(p & 32'h7F);
    k = int'(n & 32'h3F);
    if (s >= 64) return 32'h0;
    v = {hi, lo} >> s;
    if (k == 0 || k >= 32) m = 64'hFFFF_FFFF;
    else m = (64'd1 << k) - 64'd1;
    return 32'(v & m);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: result %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [31:0] lo, logic [31:0] hi,
                       logic [31:0] p, logic [31:0] n);
    @(negedge clk);
    in_valid = 1'b1;
    lo_word = lo; hi_word = hi; pos = p; len = n;
    last_exp = model(lo, hi, p, n);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R9: out_valid 1 expected 0 (no pending vector)");
      end else begin
        check(tag_q.pop_front(), result, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    vectors++; misses++;
    $display("FAIL watchdog: run incomplete expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    a = 32'h89AB_CDEF;
    b = 32'h0123_4567;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'b0, out_valid}, 32'h0);
    rst = 1'b0;

    apply("R1", a, b, 32, 0);
    apply("R1", a, b, 0, 0);
    apply("R6", a, b, 4, 0);
    apply("R4", a, b, 31, 0);
    apply("R4", a, b, 63, 0);
    apply("R4", a, b, 40, 32);
    apply("R3", a, b, 64, 0);
    apply("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 127, 1);
    apply("R3", a, b, 64 + 28, 8);
    apply("R2", a, b, 32'h0000_0080 | 32'd8, 4);
    apply("R2", a, b, 32'hFFFF_FF80 | 32'd36, 12);
    apply("R5", a, b, 0, 1);
    apply("R5", a, b, 12, 31);
    apply("R5", a, b, 60, 31);
    apply("R7", a, b, 8, 32);
    apply("R7", a, b, 8, 63);
    apply("R7", a, b, 8, 64);
    apply("R7", a, b, 8, 65);
    apply("R8", a, b, 28, 8);
    apply("R8", a, b, 30, 5);
    apply("R8", a, b, 16, 32);

    @(negedge clk);
    in_valid = 1'b0;
    lo_word = 32'hDEAD_BEEF; hi_word = 32'h5555_AAAA; pos = 1; len = 3;
    @(negedge clk);
    check("R10 valid low", {31'b0, out_valid}, 32'h0);
    check("R10 result held", result, last_exp);

    for (int i = 0; i < 300; i++)
      apply("R4 random", $urandom, $urandom, $urandom, $urandom);
    for (int i = 0; i < 100; i++)
      apply("R5 random", $urandom, $urandom, $urandom % 64, $urandom % 34);

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; misses++;
      $display("FAIL R9: %0d results missing expected 0", exp_q.size());
    end

    rst = 1'b1;
    apply("R9 reset", a, b, 0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 reset clears valid", {31'b0, out_valid}, 32'h0);
    exp_q.delete();
    tag_q.delete();
    rst = 1'b0;
    finish_run();
  end
endmodule